// File: doc/BRIEF.md
# Bank State Tracker

This block keeps a running record of which of several memory banks holds an open row, and which row that is. Every cycle it examines one decoded command together with a bank number, a row number and the A10 address flag. It then gives a same-cycle verdict: either accepted, or rejected with a reason code. Only accepted commands change state.

Each bank has its own minimum-spacing down-counters for activate-to-access, activate-to-precharge, precharge-to-activate and the self-timed close. Two counters are shared by all banks: activate-to-activate spacing and the write-to-read turnaround. A read or write with A10 set marks its bank for an automatic precharge. The block fires that precharge itself once the burst has ended and the bank's minimum active time has passed. A controller uses the verdict to decide whether to put the command on the memory bus this cycle or hold it back.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank is idle, no self-timed precharge is signalled, and a NOP (command code 0) raises neither accept nor reject. Command codes: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate. Reason codes: 0 none, 1 bank not open, 2 spacing not met, 3 bank already open.
- R2: An activate to an idle bank is accepted. From the next cycle that bank reads as open and holds the given row. An activate to a bank that is already open is rejected with reason 3.
- R3: A read or write to a bank with no open row, or to a bank whose self-timed precharge is pending, is rejected with reason 1.
- R4: A read or write to an open bank is rejected with reason 2 until T_RCD cycles after the accepted activate to that bank.
- R5: An activate is rejected with reason 2 until T_RRD cycles after the previous accepted activate to any bank.
- R6: A read is rejected with reason 2 until BURST+T_WTR cycles after the last accepted write.
- R7: A precharge with A10 low to an open bank is rejected with reason 2 until T_RAS cycles after that bank's activate. Once accepted, the bank is idle from the next cycle. An activate to that bank is then rejected with reason 2 until T_RP cycles after the close.
- R8: A precharge with A10 low to an idle bank is accepted and changes no bank state.
- R9: A precharge with A10 high is rejected with reason 2 while any open bank is inside its T_RAS window. Otherwise it is accepted and every open bank is idle from the next cycle.
- R10: A read or write with A10 high arms a self-timed precharge. The bank's bit in ap_fire rises in the first cycle that is both at least BURST cycles after the command and at least T_RAS cycles after the activate. The bank is idle from the following cycle, and the T_RP spacing then applies.
- R11: A burst terminate (code 5) is always accepted and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command code |
| bank | input | BW | Target bank |
| row | input | ROW_W | Row number for activate |
| a10 | input | 1 | Auto-precharge (read/write) or all-banks (precharge) |
| accept | output | 1 | Command is legal and takes effect |
| reject | output | 1 | Command is illegal and is dropped |
| reason | output | 2 | Rejection cause, 0 when accepted |
| bank_open | output | NB | One bit per bank, set while a row is open |
| open_row | output | NB*ROW_W | Open row of each bank, bank 0 in the low bits |
| ap_fire | output | NB | Self-timed precharge taking place this cycle |

## Verification
The checker watches several rules on every cycle. An accepted activate must open its bank. Accepted reads and writes may only target open banks. A reason of "already open" may only appear on an open bank. Accepted activates must never fall on consecutive cycles. Idle-bank precharges must leave the open set alone. A fired self-timed precharge must close its bank. The exact spacing values, on the other hand, can only be shown by the directed scenarios, because the checker does not count cycles. These values are the first legal cycle after activate, write, close and activate, and the cycle in which auto-precharge fires when the burst or the active time is the later limit.

// File: rtl/bank_state_tracker.sv
module bank_state_tracker #(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RRD = 2,
  parameter int T_WTR = 2,
  parameter int BURST = 2,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            cmd,
  input  logic [BW-1:0]         bank,
  input  logic [ROW_W-1:0]      row,
  input  logic                  a10,
  output logic                  accept,
  output logic                  reject,
  output logic [1:0]            reason,
  output logic [NB-1:0]         bank_open,
  output logic [NB*ROW_W-1:0]   open_row,
  output logic [NB-1:0]         ap_fire
);
  localparam int CW = $clog2(T_RCD + T_RP + T_RAS + T_RRD + T_WTR + BURST + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_PRE = 3'd4;
  localparam logic [1:0] RS_OK = 2'd0, RS_CLOSED = 2'd1,
                         RS_TIMING = 2'd2, RS_OPEN = 2'd3;

  logic [NB-1:0]    open_q, pend_q, ras_nz, usable;
  logic [ROW_W-1:0] row_q [NB];
  logic [CW-1:0]    rcd_q [NB];
  logic [CW-1:0]    rp_q  [NB];
  logic [CW-1:0]    ras_q [NB];
  logic [CW-1:0]    apc_q [NB];
  logic [CW-1:0]    rrd_q, wtr_q;
  logic [1:0]       rsn;
  logic             acc;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign ras_nz[i]  = ras_q[i] != '0;
    assign ap_fire[i] = pend_q[i] && apc_q[i] == '0 && ras_q[i] == '0;
    assign open_row[i*ROW_W +: ROW_W] = row_q[i];
  end

  assign usable    = open_q & ~pend_q;
  assign bank_open = open_q;

  always_comb begin
    rsn = RS_OK;
    case (cmd)
      C_ACT:
        if (open_q[bank]) rsn = RS_OPEN;
        else if (rp_q[bank] != '0 || rrd_q != '0) rsn = RS_TIMING;
      C_RD, C_WR:
        if (!usable[bank]) rsn = RS_CLOSED;
        else if (rcd_q[bank] != '0 || (cmd == C_RD && wtr_q != '0)) rsn = RS_TIMING;
      C_PRE:
        if (a10) begin
          if (|(usable & ras_nz)) rsn = RS_TIMING;
        end else if (usable[bank] && ras_nz[bank]) rsn = RS_TIMING;
      default: rsn = RS_OK;
    endcase
  end

  assign acc    = (cmd != C_NOP) && (rsn == RS_OK);
  assign accept = acc;
  assign reject = (cmd != C_NOP) && (rsn != RS_OK);
  assign reason = rsn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      pend_q <= '0;
      rrd_q  <= '0;
      wtr_q  <= '0;
      for (int i = 0; i < NB; i++) begin
        row_q[i] <= '0;
        rcd_q[i] <= '0;
        rp_q[i]  <= '0;
        ras_q[i] <= '0;
        apc_q[i] <= '0;
      end
    end else begin
      rrd_q <= dec(rrd_q);
      wtr_q <= dec(wtr_q);
      if (acc && cmd == C_ACT) rrd_q <= CW'(T_RRD - 1);
      if (acc && cmd == C_WR)  wtr_q <= CW'(BURST + T_WTR - 1);
      for (int i = 0; i < NB; i++) begin
        rcd_q[i] <= dec(rcd_q[i]);
        rp_q[i]  <= dec(rp_q[i]);
        ras_q[i] <= dec(ras_q[i]);
        apc_q[i] <= dec(apc_q[i]);
        if (ap_fire[i]) begin
          open_q[i] <= 1'b0;
          pend_q[i] <= 1'b0;
          rp_q[i]   <= CW'(T_RP - 1);
        end
        if (acc) begin
          case (cmd)
            C_ACT:
              if (bank == BW'(i)) begin
                open_q[i] <= 1'b1;
                row_q[i]  <= row;
                rcd_q[i]  <= CW'(T_RCD - 1);
                ras_q[i]  <= CW'(T_RAS - 1);
              end
            C_RD, C_WR:
              if (bank == BW'(i) && a10) begin
                pend_q[i] <= 1'b1;
                apc_q[i]  <= CW'(BURST - 1);
              end
            C_PRE:
              if ((a10 || bank == BW'(i)) && usable[i]) begin
                open_q[i] <= 1'b0;
                rp_q[i]   <= CW'(T_RP - 1);
              end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module bank_state_tracker_chk #(
  parameter int NB    = 4,
  parameter int BW    = 2,
  parameter int T_RRD = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd,
  input logic [BW-1:0] bank,
  input logic          a10,
  input logic          accept,
  input logic [1:0]    reason,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] ap_fire
);
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 3'd1) |=> bank_open[$past(bank)]);

  assert_already_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reason == 2'd3) |-> bank_open[bank]);

  assert_access_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd == 3'd2 || cmd == 3'd3)) |-> bank_open[bank]);

  assert_act_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && accept && cmd == 3'd1) |=> !(accept && cmd == 3'd1));

  assert_idle_pre_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 3'd4 && !a10 && !bank_open[bank] && ap_fire == '0) |=> $stable(bank_open));

  assert_fire_on_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_fire & ~bank_open) == '0);

  assert_fire_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_fire != '0) |=> ((bank_open & $past(ap_fire)) == '0));
endmodule

bind bank_state_tracker bank_state_tracker_chk #(.NB(NB), .BW(BW), .T_RRD(T_RRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .a10(a10), .accept(accept),
  .reason(reason), .bank_open(bank_open), .ap_fire(ap_fire));

// File: tb/bank_state_tracker_test.sv
module bank_state_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  bank = 2'd0;
  logic [12:0] row = 13'd0;
  logic        a10 = 1'b0;
  logic        accept, reject;
  logic [1:0]  reason;
  logic [3:0]  bank_open, ap_fire;
  logic [51:0] open_row;
  int total = 0;
  int bad = 0;

  bank_state_tracker uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .row(row), .a10(a10),
    .accept(accept), .reject(reject), .reason(reason), .bank_open(bank_open),
    .open_row(open_row), .ap_fire(ap_fire));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = 3'd0; bank = 2'd0; row = 13'd0; a10 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd = 3'd0; a10 = 1'b0;
      #1;
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r,
                       input logic a, input bit exp_acc, input logic [1:0] exp_rs, input string req);
    @(negedge clk);
    cmd = c; bank = b; row = r; a10 = a;
    #1;
    check(accept == exp_acc && reject == !exp_acc, req, "accept", accept, exp_acc);
    check(reason == (exp_acc ? 2'd0 : exp_rs), req, "reason", reason, exp_acc ? 0 : exp_rs);
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    check(bank_open == 4'b0, "R1", "bank_open", bank_open, 0);
    check(ap_fire == 4'b0, "R1", "ap_fire", ap_fire, 0);
    check(!accept && !reject, "R1", "nop verdict", {accept, reject}, 0);
  endtask

  task automatic t_activate();
    do_reset();
    issue(3'd1, 2'd0, 13'h155, 1'b0, 1, 0, "R2");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 0, 2, "R4");
    issue(3'd3, 2'd0, 13'd0, 1'b0, 0, 2, "R4");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 1, 0, "R4");
    check(bank_open == 4'b0001, "R2", "bank_open", bank_open, 1);
    check(open_row[12:0] == 13'h155, "R2", "open_row", open_row[12:0], 'h155);
    issue(3'd1, 2'd0, 13'd7, 1'b0, 0, 3, "R2");
  endtask

  task automatic t_not_open();
    do_reset();
    issue(3'd2, 2'd2, 13'd0, 1'b0, 0, 1, "R3");
    issue(3'd3, 2'd3, 13'd0, 1'b0, 0, 1, "R3");
  endtask

  task automatic t_rrd();
    do_reset();
    issue(3'd1, 2'd1, 13'd10, 1'b0, 1, 0, "R5");
    issue(3'd1, 2'd2, 13'd20, 1'b0, 0, 2, "R5");
    issue(3'd1, 2'd2, 13'd20, 1'b0, 1, 0, "R5");
    idle(1);
    check(bank_open == 4'b0110, "R5", "bank_open", bank_open, 6);
  endtask

  task automatic t_wtr();
    do_reset();
    issue(3'd1, 2'd0, 13'd3, 1'b0, 1, 0, "R6");
    idle(2);
    issue(3'd3, 2'd0, 13'd0, 1'b0, 1, 0, "R6");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 0, 2, "R6");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 0, 2, "R6");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 0, 2, "R6");
    issue(3'd2, 2'd0, 13'd0, 1'b0, 1, 0, "R6");
  endtask

  task automatic t_ras_rp();
    do_reset();
    issue(3'd1, 2'd1, 13'd9, 1'b0, 1, 0, "R7");
    issue(3'd4, 2'd1, 13'd0, 1'b0, 0, 2, "R7");
    idle(5);
    issue(3'd4, 2'd1, 13'd0, 1'b0, 0, 2, "R7");
    issue(3'd4, 2'd1, 13'd0, 1'b0, 1, 0, "R7");
    idle(1);
    check(bank_open == 4'b0, "R7", "bank_open", bank_open, 0);
    issue(3'd1, 2'd1, 13'd9, 1'b0, 0, 2, "R7");
    issue(3'd1, 2'd1, 13'd9, 1'b0, 1, 0, "R7");
  endtask

  task automatic t_pre_idle();
    do_reset();
    issue(3'd1, 2'd0, 13'h0AA, 1'b0, 1, 0, "R8");
    idle(1);
    issue(3'd4, 2'd2, 13'd0, 1'b0, 1, 0, "R8");
    idle(1);
    check(bank_open == 4'b0001, "R8", "bank_open", bank_open, 1);
    check(open_row[12:0] == 13'h0AA, "R8", "open_row", open_row[12:0], 'hAA);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(3'd1, 2'd0, 13'd1, 1'b0, 1, 0, "R9");
    idle(1);
    issue(3'd1, 2'd3, 13'd2, 1'b0, 1, 0, "R9");
    issue(3'd4, 2'd0, 13'd0, 1'b1, 0, 2, "R9");
    idle(6);
    issue(3'd4, 2'd0, 13'd0, 1'b1, 1, 0, "R9");
    idle(1);
    check(bank_open == 4'b0, "R9", "bank_open", bank_open, 0);
  endtask

  task automatic t_auto();
    do_reset();
    issue(3'd1, 2'd2, 13'd5, 1'b0, 1, 0, "R10");
    idle(2);
    issue(3'd2, 2'd2, 13'd0, 1'b1, 1, 0, "R10");
    issue(3'd2, 2'd2, 13'd0, 1'b0, 0, 1, "R3");
    for (int k = 0; k < 3; k++) begin
      idle(1);
      check(ap_fire == 4'b0 && bank_open[2], "R10", "early fire", ap_fire, 0);
    end
    idle(1);
    check(ap_fire == 4'b0100, "R10", "ap_fire", ap_fire, 4);
    issue(3'd1, 2'd2, 13'd5, 1'b0, 0, 2, "R10");
    check(bank_open == 4'b0, "R10", "bank_open", bank_open, 0);
    do_reset();
    issue(3'd1, 2'd1, 13'd6, 1'b0, 1, 0, "R10");
    idle(9);
    issue(3'd3, 2'd1, 13'd0, 1'b1, 1, 0, "R10");
    idle(1);
    check(ap_fire == 4'b0, "R10", "burst fire early", ap_fire, 0);
    idle(1);
    check(ap_fire == 4'b0010, "R10", "burst fire", ap_fire, 2);
  endtask

  task automatic t_bst();
    do_reset();
    issue(3'd1, 2'd0, 13'd4, 1'b0, 1, 0, "R11");
    issue(3'd5, 2'd0, 13'd0, 1'b0, 1, 0, "R11");
    issue(3'd5, 2'd1, 13'd0, 1'b0, 1, 0, "R11");
    idle(1);
    check(bank_open == 4'b0001, "R11", "bank_open", bank_open, 1);
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_activate();
    t_not_open();
    t_rrd();
    t_wtr();
    t_ras_rp();
    t_pre_idle();
    t_pre_all();
    t_auto();
    t_bst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule